// File: doc/BRIEF.md
# Variable Pulse Width Symbol Transmitter

This block serialises a stream of bytes onto a single-wire bus using variable pulse width coding. Each bit is one symbol, and every symbol starts with a change of the bus level, so the drive alternates between active and passive from bit to bit. How long a symbol lasts depends on two things: the bit value and the level the bus holds during that symbol. Every duration is measured in pulses of a one-microsecond timing strobe, counted by one down-counter that is reloaded at each transition.

A frame opens in one of two ways. A request without the response flag opens it with a fixed 200 us active start pulse. A request with the response flag opens it with a normalization symbol for an in-frame response. That symbol is active and lasts 64 us when the response carries a CRC, or 128 us when it does not. Bytes then follow, most significant bit first, and each byte starts on a passive symbol. The frame ends with a 200 us passive end-of-data period. The frame also ends this way if no next byte is offered at the point of handoff. A busy flag covers the whole frame.

Top module: `vpw_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `bus_active` is 0, `busy` is 0 and `byte_ready` is 1.
- R2: When `byte_valid` is seen while idle with `nb_req` low, the byte is taken and the bus is driven active for exactly 200 strobe pulses.
- R3: When `byte_valid` is seen while idle with `nb_req` high, the byte is taken and the bus is driven active for 64 strobe pulses if `nb_with_crc` is 1, or for 128 if it is 0. No 200-pulse start symbol is sent in this case.
- R4: A data bit symbol lasts 64 pulses for a 0 sent passive or a 1 sent active. It lasts 128 pulses for a 0 sent active or a 1 sent passive.
- R5: Bits leave most significant first. The first bit of every byte is passive, and each later bit takes the opposite level of the bit before it, so the eighth bit of a byte is active.
- R6: During a frame, `byte_ready` is high for a single cycle, only in the cycle that ends the last bit of a byte not flagged last, and only while `tick_us` is high. A byte offered then is sent with no gap.
- R7: After the last bit of a byte flagged with `byte_last`, or after a handoff at which `byte_valid` is low, the bus is passive for 200 pulses and the block then returns to idle.
- R8: `busy` rises together with the first active drive and falls in the cycle the end-of-data period expires, with the bus passive.
- R9: The bus level and `busy` never change during a frame in a cycle without `tick_us`. A pause of the strobe stretches the current symbol without changing its length counted in pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle timing strobe, once per microsecond |
| byte_valid | input | 1 | A byte is offered |
| byte_data | input | 8 | Offered byte, sent MSB first |
| byte_last | input | 1 | Offered byte ends the frame |
| byte_ready | output | 1 | Offered byte is taken in this cycle if valid |
| nb_req | input | 1 | Start with a normalization symbol instead of the start pulse |
| nb_with_crc | input | 1 | Normalization symbol announces a response with CRC (short form) |
| bus_active | output | 1 | 1 drives the bus to its active level |
| busy | output | 1 | A frame is in progress |

## Verification
Frames are sent with bytes 0xA5, 0x00/0xFF, 0x5A, 0x3C and 0xC3/0x81. This puts each bit value on each bus level, in runs and in alternation, so a swapped entry in the duration table, a wrong bit order or a wrong starting level each gives a different list of pulse lengths. Both forms of the normalization symbol are compared against the start pulse. A two-byte frame tests the gapless handoff. A frame that offers no byte at the handoff must fall back to end-of-data. A pause of the strobe in the middle of a frame separates counting in strobe pulses from counting in clock cycles.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_BITS = 2'd2,
        ST_EOD  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic load;
        logic shift;
    } shift_ctl_t;

    // A symbol is long when the bit value and the bus level differ.
    function automatic logic sym_is_long(input logic bit_val, input logic active);
        return bit_val ^ active;
    endfunction

endpackage

// File: rtl/vpw_down_cnt.sv
module vpw_down_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = tick && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/vpw_byte_shift.sv
module vpw_byte_shift
    import vpw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              last_in,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              at_end,
    output logic              is_last
);
    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
            last_q <= 1'b0;
        end else if (ctl.load) begin
            sreg_q <= data_in;
            idx_q  <= '0;
            last_q <= last_in;
        end else if (ctl.shift) begin
            sreg_q <= sreg_q << 1;
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign cur_bit  = sreg_q[BYTE_W-1];
    assign next_bit = sreg_q[BYTE_W-2];
    assign at_end   = (idx_q == IDX_W'(BYTE_W-1));
    assign is_last  = last_q;
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
    import vpw_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SHORT_US = 64,
    parameter int LONG_US  = 128,
    parameter int SOF_US   = 200,
    parameter int EOD_US   = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_us,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    output logic              byte_ready,
    input  logic              nb_req,
    input  logic              nb_with_crc,
    output logic              bus_active,
    output logic              busy
);
    localparam int MAX_A  = (SHORT_US > LONG_US) ? SHORT_US : LONG_US;
    localparam int MAX_B  = (SOF_US > EOD_US) ? SOF_US : EOD_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_US + 1);

    tx_state_e        st_q, st_n;
    logic             lvl_q, lvl_n;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expire;
    shift_ctl_t       ctl;
    logic             cur_bit, next_bit, at_end, is_last;

    function automatic logic [CNT_W-1:0] dur(input logic b, input logic a);
        return sym_is_long(b, a) ? CNT_W'(LONG_US) : CNT_W'(SHORT_US);
    endfunction

    vpw_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_us),
        .load     (ld),
        .load_val (ld_val),
        .expire   (expire)
    );

    vpw_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .data_in  (byte_data),
        .last_in  (byte_last),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .at_end   (at_end),
        .is_last  (is_last)
    );

    always_comb begin
        st_n       = st_q;
        lvl_n      = lvl_q;
        ld         = 1'b0;
        ld_val     = '0;
        ctl        = '0;
        byte_ready = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                byte_ready = 1'b1;
                if (byte_valid) begin
                    ctl.load = 1'b1;
                    st_n     = ST_PRE;
                    lvl_n    = 1'b1;
                    ld       = 1'b1;
                    if (nb_req)
                        ld_val = nb_with_crc ? CNT_W'(SHORT_US) : CNT_W'(LONG_US);
                    else
                        ld_val = CNT_W'(SOF_US);
                end
            end
            ST_PRE: begin
                if (expire) begin
                    st_n   = ST_BITS;
                    lvl_n  = 1'b0;
                    ld     = 1'b1;
                    ld_val = dur(cur_bit, 1'b0);
                end
            end
            ST_BITS: begin
                if (expire) begin
                    if (!at_end) begin
                        ctl.shift = 1'b1;
                        lvl_n     = ~lvl_q;
                        ld        = 1'b1;
                        ld_val    = dur(next_bit, ~lvl_q);
                    end else begin
                        byte_ready = !is_last;
                        lvl_n      = 1'b0;
                        ld         = 1'b1;
                        if (!is_last && byte_valid) begin
                            ctl.load = 1'b1;
                            ld_val   = dur(byte_data[BYTE_W-1], 1'b0);
                        end else begin
                            st_n   = ST_EOD;
                            ld_val = CNT_W'(EOD_US);
                        end
                    end
                end
            end
            ST_EOD: begin
                if (expire)
                    st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            lvl_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            lvl_q <= lvl_n;
        end
    end

    assign bus_active = lvl_q;
    assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk (
    input logic clk,
    input logic rst,
    input logic tick_us,
    input logic byte_ready,
    input logic bus_active,
    input logic busy
);
    assert_idle_passive_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_active);

    assert_handoff_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && byte_ready) |-> tick_us);

    assert_handoff_single_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && byte_ready) |=> !byte_ready);

    assert_eod_passive_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !bus_active);

    assert_start_active_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> bus_active);

    assert_level_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_us) |=> $stable(bus_active));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_us) |=> busy);
endmodule

bind vpw_tx vpw_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_us    (tick_us),
    .byte_ready (byte_ready),
    .bus_active (bus_active),
    .busy       (busy)
);

// File: tb/vpw_tx_tb.sv
module vpw_tx_tb;
    localparam int SHORT = 64;
    localparam int LONG  = 128;
    localparam int SOF   = 200;
    localparam int EOD   = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_last = 1'b0;
    logic       byte_ready;
    logic       nb_req = 1'b0;
    logic       nb_with_crc = 1'b0;
    logic       bus_active;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;

    vpw_tx u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_us     (tick_us),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_last   (byte_last),
        .byte_ready  (byte_ready),
        .nb_req      (nb_req),
        .nb_with_crc (nb_with_crc),
        .bus_active  (bus_active),
        .busy        (busy)
    );

    always #10 clk = ~clk;

    // strobe generator and symbol-length monitor, both at the falling edge
    bit tick_en = 1'b1;
    int div = 0;
    int seg = 0;
    bit prev_bus = 1'b0;
    bit busy_prev = 1'b0;
    int seg_len [0:31];
    bit seg_lvl [0:31];
    int nseg = 0;
    int eod_len = -1;

    always @(negedge clk) begin
        if (tick_us) seg++;
        if (bus_active !== prev_bus) begin
            if (busy_prev && nseg < 32) begin
                seg_len[nseg] = seg;
                seg_lvl[nseg] = prev_bus;
                nseg++;
            end
            seg = 0;
            prev_bus = bus_active;
        end
        if (busy_prev && !busy) eod_len = seg;
        busy_prev = busy;
        div = (div + 1) % 4;
        tick_us = tick_en && (div == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [7:0] bytes [0:3];

    // send n bytes; the final one carries byte_last only if final_last is set
    task automatic run_frame(input int n, input bit use_nb, input bit crc,
                             input bit final_last, input string req_pre);
        int exp_len [0:31];
        bit exp_lvl [0:31];
        int ne;
        nseg = 0;
        eod_len = -1;
        @(negedge clk); #3;
        byte_valid  = 1'b1;
        byte_data   = bytes[0];
        byte_last   = (n == 1) && final_last;
        nb_req      = use_nb;
        nb_with_crc = crc;
        for (int i = 0; i < n; i++) begin
            while (!byte_ready) begin
                @(negedge clk); #2;
            end
            if (i > 0) chk(tick_us === 1'b1, "R6", tick_us, 1, "handoff strobe");
            @(posedge clk);
            @(negedge clk); #3;
            chk(byte_ready === 1'b0, "R6", byte_ready, 0, "ready single cycle");
            nb_req = 1'b0;
            if (i + 1 < n) begin
                byte_data = bytes[i+1];
                byte_last = (i + 1 == n - 1) && final_last;
            end else begin
                byte_valid = 1'b0;
                byte_last  = 1'b0;
            end
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        // expected symbol list
        ne = 0;
        exp_lvl[ne] = 1'b1;
        exp_len[ne] = use_nb ? (crc ? SHORT : LONG) : SOF;
        ne++;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                bit lv = ((7 - b) % 2) == 1;
                bit bv = bytes[i][b];
                exp_lvl[ne] = lv;
                exp_len[ne] = (bv != lv) ? LONG : SHORT;
                ne++;
            end
        end
        chk(nseg == ne, "R5", nseg, ne, "symbol count");
        chk(seg_lvl[0] == 1'b1 && seg_len[0] == exp_len[0], req_pre, seg_len[0],
            exp_len[0], "opening active symbol");
        for (int k = 1; k < ne && k < nseg; k++) begin
            chk(seg_lvl[k] == exp_lvl[k], "R5", seg_lvl[k], exp_lvl[k], "bit level");
            chk(seg_len[k] == exp_len[k], "R4", seg_len[k], exp_len[k], "bit duration");
        end
        chk(eod_len == EOD, "R7", eod_len, EOD, "end-of-data length");
        chk(bus_active === 1'b0 && busy === 1'b0, "R8", {bus_active, busy}, 0,
            "idle after frame");
        chk(byte_ready === 1'b1, "R1", byte_ready, 1, "ready when idle");
    endtask

    task automatic t_reset();
        chk(bus_active === 1'b0, "R1", bus_active, 0, "bus after reset");
        chk(busy === 1'b0, "R1", busy, 0, "busy after reset");
        chk(byte_ready === 1'b1, "R1", byte_ready, 1, "ready after reset");
    endtask

    task automatic t_single_sof();   // R2 R4 R5 R7
        bytes[0] = 8'hA5;
        run_frame(1, 1'b0, 1'b0, 1'b1, "R2");
    endtask

    task automatic t_two_bytes();    // R6 gapless handoff
        bytes[0] = 8'h00;
        bytes[1] = 8'hFF;
        run_frame(2, 1'b0, 1'b0, 1'b1, "R2");
    endtask

    task automatic t_pause();        // R9 stalled strobe
        bit held;
        bytes[0] = 8'h5A;
        fork
            run_frame(1, 1'b0, 1'b0, 1'b1, "R2");
            begin
                repeat (1200) @(negedge clk);
                tick_en = 1'b0;
                held = bus_active;
                repeat (400) @(negedge clk);
                chk(bus_active === held && busy === 1'b1, "R9", bus_active, held,
                    "level held without strobe");
                tick_en = 1'b1;
            end
        join
    endtask

    task automatic t_nb_crc();       // R3 short form
        bytes[0] = 8'h3C;
        run_frame(1, 1'b1, 1'b1, 1'b1, "R3");
    endtask

    task automatic t_nb_nocrc();     // R3 long form, two response bytes
        bytes[0] = 8'hC3;
        bytes[1] = 8'h81;
        run_frame(2, 1'b1, 1'b0, 1'b1, "R3");
    endtask

    task automatic t_underrun();     // R7 no byte at handoff
        bytes[0] = 8'h96;
        run_frame(1, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        t_reset();
        t_single_sof();
        t_two_bytes();
        t_pause();
        t_nb_crc();
        t_nb_nocrc();
        t_underrun();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule